// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several processors that share one memory build atomic read-modify-write sequences out of a load-linked (LL) and a store-conditional (SC). Each processor port issues one command per cycle: an LL, an SC, a plain store, or nothing. The block holds one reservation (a valid flag and an address) for each port. It also watches a snoop input that reports writes made by agents outside the block. An SC commits its data to memory only while the port's reservation is still intact. The port learns the outcome through a success flag and a commit flag.

A small register-file memory sits inside the block, so the effect of every committed or refused store can be read back through a later LL. Commands that arrive in the same cycle are ordered by port index, lowest first. Every write, whether a plain store, a successful SC or a snooped external write, removes each reservation that names the written address. A refused SC leaves both memory and the commit output untouched. Responses come from registers and appear exactly one cycle after the command.

Top module: `llsc_monitor`

## Requirements
- R1: An LL (command code 2'b01) returns, one cycle later on its port, the memory word held at its address before that cycle's writes. It commits nothing, and it records a reservation for that port on that address.
- R2: Every command other than 2'b00 produces rsp_valid on its port exactly one cycle later, and 2'b00 produces none. A plain store (2'b11) always writes memory and raises rsp_commit with rsp_ok low.
- R3: An SC (2'b10) whose port holds a valid reservation on the same address, with no intervening write, succeeds: rsp_ok and rsp_commit rise one cycle later and memory takes the SC data.
- R4: An SC fails when its port holds no reservation or holds one for a different address. A failed SC to another address leaves the existing reservation usable.
- R5: Any write to a reserved address clears that reservation, whether it comes from another port's store or SC or from the snoop input. A write to a different address does not.
- R6: A failed SC raises neither rsp_ok nor rsp_commit and leaves memory unchanged.
- R7: A successful SC clears every reservation on its address, its own included, so that a second SC from any port to that address fails.
- R8: A new LL replaces the port's earlier reservation.
- R9: Commands in one cycle are ordered by port index, lowest first. When two SCs target one reserved address, only the lowest-numbered port succeeds. An SC also fails if a lower-numbered port stores to its address in the same cycle, or if the snoop reports a write to it in that cycle.
- R10: An LL issued in a cycle when another port or the snoop writes its address returns the old word and leaves no valid reservation.
- R11: Synchronous active-high reset clears all reservations and the response outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | N_PORTS*2 | Command per port: 00 none, 01 LL, 10 SC, 11 store |
| req_addr | input | N_PORTS*ADDR_W | Word address per port |
| req_wdata | input | N_PORTS*DATA_W | Store / SC data per port |
| snoop_valid | input | 1 | An external agent wrote memory this cycle |
| snoop_addr | input | ADDR_W | Address of the external write |
| rsp_valid | output | N_PORTS | Response present, one cycle after a command |
| rsp_ok | output | N_PORTS | SC succeeded |
| rsp_commit | output | N_PORTS | The command's write reached memory |
| rsp_rdata | output | N_PORTS*DATA_W | Word read at the command's address |

## Verification
The hardest cases to reach are the same-cycle races. Two ports must hold reservations on one address and then issue SCs in the very same cycle. A lower-numbered store or a snoop must land in exactly the cycle of an SC or of an LL. The bench drives every port's command in one call per cycle, so it can first build matching reservations over earlier cycles and then fire the colliding commands together. The results of refused SCs are then read back through a fresh LL, which shows that memory kept its old word.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_LL   = 2'b01,
    OP_SC   = 2'b10,
    OP_ST   = 2'b11
  } op_e;
endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic              set_valid_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              kill_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (set_i) begin
      valid_o <= set_valid_i;
      addr_o  <= set_addr_i;
    end else if (kill_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_order.sv
module llsc_order import llsc_pkg::*; #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 4
) (
  input  logic [N_PORTS-1:0][1:0]        op_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] addr_i,
  input  logic [N_PORTS-1:0]             resv_valid_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] resv_addr_i,
  input  logic                           snoop_valid_i,
  input  logic [ADDR_W-1:0]              snoop_addr_i,
  output logic [N_PORTS-1:0]             wr_en_o,
  output logic [N_PORTS-1:0]             sc_ok_o,
  output logic [N_PORTS-1:0]             kill_o,
  output logic [N_PORTS-1:0]             ll_keep_o
);
  always_comb begin
    logic [N_PORTS-1:0] we;
    logic [N_PORTS-1:0] ok;
    logic               earlier;
    logic               hit;
    we = '0;
    ok = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      earlier = 1'b0;
      for (int j = 0; j < i; j++)
        if (we[j] && addr_i[j] == addr_i[i]) earlier = 1'b1;
      hit = snoop_valid_i && snoop_addr_i == addr_i[i];
      ok[i] = op_e'(op_i[i]) == OP_SC && resv_valid_i[i] &&
              resv_addr_i[i] == addr_i[i] && !hit && !earlier;
      we[i] = op_e'(op_i[i]) == OP_ST || ok[i];
    end
    for (int k = 0; k < N_PORTS; k++) begin
      kill_o[k]    = snoop_valid_i && snoop_addr_i == resv_addr_i[k];
      ll_keep_o[k] = !(snoop_valid_i && snoop_addr_i == addr_i[k]);
      for (int j = 0; j < N_PORTS; j++) begin
        if (we[j] && addr_i[j] == resv_addr_i[k]) kill_o[k] = 1'b1;
        if (we[j] && addr_i[j] == addr_i[k]) ll_keep_o[k] = 1'b0;
      end
    end
    wr_en_o = we;
    sc_ok_o = ok;
  end
endmodule

// File: rtl/llsc_regfile.sv
module llsc_regfile #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic                           clk,
  input  logic [N_PORTS-1:0]             we_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] waddr_i,
  input  logic [N_PORTS-1:0][DATA_W-1:0] wdata_i,
  input  logic [N_PORTS-1:0][ADDR_W-1:0] raddr_i,
  output logic [N_PORTS-1:0][DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // Ascending loop: a higher port's write lands last, matching port order.
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_PORTS; i++)
      if (we_i[i]) mem[waddr_i[i]] <= wdata_i[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_PORTS; i++)
      rdata_o[i] <= mem[raddr_i[i]];
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor import llsc_pkg::*; #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_PORTS*2-1:0]        req_op,
  input  logic [N_PORTS*ADDR_W-1:0]   req_addr,
  input  logic [N_PORTS*DATA_W-1:0]   req_wdata,
  input  logic                        snoop_valid,
  input  logic [ADDR_W-1:0]           snoop_addr,
  output logic [N_PORTS-1:0]          rsp_valid,
  output logic [N_PORTS-1:0]          rsp_ok,
  output logic [N_PORTS-1:0]          rsp_commit,
  output logic [N_PORTS*DATA_W-1:0]   rsp_rdata
);
  logic [N_PORTS-1:0][1:0]        op_a;
  logic [N_PORTS-1:0][ADDR_W-1:0] addr_a;
  logic [N_PORTS-1:0][DATA_W-1:0] wd_a;
  logic [N_PORTS-1:0][DATA_W-1:0] rd_a;
  logic [N_PORTS-1:0]             resv_valid;
  logic [N_PORTS-1:0][ADDR_W-1:0] resv_addr;
  logic [N_PORTS-1:0]             wr_en, sc_ok, kill, ll_keep;

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    assign op_a[g]   = req_op[2*g +: 2];
    assign addr_a[g] = req_addr[g*ADDR_W +: ADDR_W];
    assign wd_a[g]   = req_wdata[g*DATA_W +: DATA_W];
    assign rsp_rdata[g*DATA_W +: DATA_W] = rd_a[g];

    llsc_resv_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .set_i      (op_e'(op_a[g]) == OP_LL),
      .set_valid_i(ll_keep[g]),
      .set_addr_i (addr_a[g]),
      .kill_i     (kill[g]),
      .valid_o    (resv_valid[g]),
      .addr_o     (resv_addr[g])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        rsp_valid[g]  <= 1'b0;
        rsp_ok[g]     <= 1'b0;
        rsp_commit[g] <= 1'b0;
      end else begin
        rsp_valid[g]  <= op_e'(op_a[g]) != OP_NONE;
        rsp_ok[g]     <= sc_ok[g];
        rsp_commit[g] <= wr_en[g];
      end
    end
  end

  llsc_order #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W)) u_order (
    .op_i         (op_a),
    .addr_i       (addr_a),
    .resv_valid_i (resv_valid),
    .resv_addr_i  (resv_addr),
    .snoop_valid_i(snoop_valid),
    .snoop_addr_i (snoop_addr),
    .wr_en_o      (wr_en),
    .sc_ok_o      (sc_ok),
    .kill_o       (kill),
    .ll_keep_o    (ll_keep)
  );

  llsc_regfile #(.N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .we_i   (wr_en),
    .waddr_i(addr_a),
    .wdata_i(wd_a),
    .raddr_i(addr_a),
    .rdata_o(rd_a)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int N_PORTS = 3,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [N_PORTS*2-1:0]      req_op,
  input logic [N_PORTS*ADDR_W-1:0] req_addr,
  input logic                      snoop_valid,
  input logic [ADDR_W-1:0]         snoop_addr,
  input logic [N_PORTS-1:0]        rsp_valid,
  input logic [N_PORTS-1:0]        rsp_ok,
  input logic [N_PORTS-1:0]        rsp_commit
);
  for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
      (req_op[2*i +: 2] != 2'b00) |=> rsp_valid[i]);
    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (rst)
      (req_op[2*i +: 2] == 2'b00) |=> !rsp_valid[i]);
    assert_store_commits_R2: assert property (@(posedge clk) disable iff (rst)
      (req_op[2*i +: 2] == 2'b11) |=> (rsp_commit[i] && !rsp_ok[i]));
    assert_ll_no_write_R1: assert property (@(posedge clk) disable iff (rst)
      (req_op[2*i +: 2] == 2'b01) |=> (!rsp_commit[i] && !rsp_ok[i]));
    assert_fail_no_write_R6: assert property (@(posedge clk) disable iff (rst)
      (req_op[2*i +: 2] == 2'b10) |=> (rsp_commit[i] == rsp_ok[i]));
    assert_snoop_blocks_sc_R5: assert property (@(posedge clk) disable iff (rst)
      (req_op[2*i +: 2] == 2'b10 && snoop_valid &&
       snoop_addr == req_addr[i*ADDR_W +: ADDR_W]) |=> !rsp_ok[i]);
    for (genvar j = i + 1; j < N_PORTS; j++) begin : g_pair
      assert_single_winner_R9: assert property (@(posedge clk) disable iff (rst)
        (req_op[2*i +: 2] == 2'b10 && req_op[2*j +: 2] == 2'b10 &&
         req_addr[i*ADDR_W +: ADDR_W] == req_addr[j*ADDR_W +: ADDR_W])
        |=> !(rsp_ok[i] && rsp_ok[j]));
    end
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int N = 3;
  localparam int AW = 4;
  localparam int DW = 8;

  typedef struct {
    int         port;
    logic [1:0] op;
    logic [7:0] data;
    bit         ok;
    bit         cm;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0]  b_op [N];
  logic [3:0]  b_ad [N];
  logic [7:0]  b_wd [N];
  logic        b_sv;
  logic [3:0]  b_sa;

  logic [N*2-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic [N-1:0]    rsp_valid, rsp_ok, rsp_commit;
  logic [N*DW-1:0] rsp_rdata;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_op[2*i +: 2]     = b_op[i];
      req_addr[i*AW +: AW] = b_ad[i];
      req_wdata[i*DW +: DW] = b_wd[i];
    end
  end

  llsc_monitor #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .snoop_valid(b_sv), .snoop_addr(b_sa),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_commit(rsp_commit),
    .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t q[$];

  // Model state kept from the requirements.
  logic [7:0] mm [16];
  bit         rv [N];
  logic [3:0] ra [N];

  task automatic check(input bit cond, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < N; i++) begin
      b_op[i] = 2'b00; b_ad[i] = '0; b_wd[i] = '0;
    end
    b_sv = 1'b0; b_sa = '0;
  endtask

  task automatic cmd(input int p, input logic [1:0] o, input logic [3:0] a,
                     input logic [7:0] d);
    b_op[p] = o; b_ad[p] = a; b_wd[p] = d;
  endtask

  // Apply the staged commands for one cycle and push the expected results.
  task automatic tick(input string tag);
    bit we [N];
    bit ok [N];
    bit earlier, keep;
    logic [7:0] old [N];
    for (int i = 0; i < N; i++) old[i] = mm[b_ad[i]];
    for (int i = 0; i < N; i++) begin
      earlier = 1'b0;
      for (int j = 0; j < i; j++) if (we[j] && b_ad[j] == b_ad[i]) earlier = 1'b1;
      ok[i] = b_op[i] == 2'b10 && rv[i] && ra[i] == b_ad[i] &&
              !(b_sv && b_sa == b_ad[i]) && !earlier;
      we[i] = b_op[i] == 2'b11 || ok[i];
    end
    for (int k = 0; k < N; k++) begin
      if (b_op[k] == 2'b01) begin
        keep = !(b_sv && b_sa == b_ad[k]);
        for (int j = 0; j < N; j++) if (we[j] && b_ad[j] == b_ad[k]) keep = 1'b0;
        rv[k] = keep; ra[k] = b_ad[k];
      end else begin
        if (b_sv && b_sa == ra[k]) rv[k] = 1'b0;
        for (int j = 0; j < N; j++) if (we[j] && b_ad[j] == ra[k]) rv[k] = 1'b0;
      end
    end
    for (int i = 0; i < N; i++) if (we[i]) mm[b_ad[i]] = b_wd[i];
    for (int i = 0; i < N; i++)
      if (b_op[i] != 2'b00)
        q.push_back('{port: i, op: b_op[i], data: old[i], ok: ok[i], cm: we[i], tag: tag});
    @(posedge clk);
    #1;
    clr();
  endtask

  // Monitor: pop one expected item per response, in port order.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        for (int i = 0; i < N; i++) begin
          if (rsp_valid[i]) begin
            if (q.size() == 0) begin
              check(1'b0, "R2", "unexpected response", i, -1);
            end else begin
              exp_t e;
              e = q.pop_front();
              check(e.port == i, e.tag, "response port", i, e.port);
              check(rsp_ok[i] == e.ok, e.tag, "sc flag", rsp_ok[i], e.ok);
              check(rsp_commit[i] == e.cm, e.tag, "commit", rsp_commit[i], e.cm);
              if (e.op == 2'b01)
                check(rsp_rdata[i*DW +: DW] == e.data, e.tag, "ll data",
                      rsp_rdata[i*DW +: DW], e.data);
            end
          end
        end
      end
    end
  end

  task automatic do_reset();
    clr();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    for (int i = 0; i < N; i++) rv[i] = 1'b0;
    check(rsp_valid == '0 && rsp_ok == '0 && rsp_commit == '0, "R11",
          "outputs after reset", {rsp_valid, rsp_ok, rsp_commit}, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mm[i] = '0;
    do_reset();
    // Fill memory (R2)
    cmd(0, 2'b11, 4'd0, 8'h10); cmd(1, 2'b11, 4'd1, 8'h21); cmd(2, 2'b11, 4'd2, 8'h32); tick("R2");
    cmd(0, 2'b11, 4'd3, 8'h43); tick("R2");
    tick("R2"); // idle cycle: no response expected
    // Basic LL then SC (R1, R3)
    cmd(0, 2'b01, 4'd0, 8'h00); tick("R1");
    cmd(0, 2'b10, 4'd0, 8'h55); tick("R3");
    cmd(1, 2'b01, 4'd0, 8'h00); tick("R3");
    // No reservation, wrong address (R4)
    cmd(2, 2'b10, 4'd1, 8'hEE); tick("R4");
    cmd(1, 2'b01, 4'd1, 8'h00); tick("R4");
    cmd(1, 2'b10, 4'd2, 8'hEE); tick("R4");
    cmd(1, 2'b10, 4'd1, 8'h66); tick("R4");
    // Intervening store, failed SC leaves memory (R5, R6)
    cmd(0, 2'b01, 4'd2, 8'h00); tick("R5");
    cmd(2, 2'b11, 4'd2, 8'h77); tick("R5");
    cmd(0, 2'b10, 4'd2, 8'h88); tick("R6");
    cmd(0, 2'b01, 4'd2, 8'h00); tick("R6");
    b_sv = 1'b1; b_sa = 4'd2; tick("R5");
    cmd(0, 2'b10, 4'd2, 8'h89); tick("R5");
    cmd(0, 2'b01, 4'd2, 8'h00); tick("R5");
    b_sv = 1'b1; b_sa = 4'd3; tick("R5");
    cmd(0, 2'b10, 4'd2, 8'h99); tick("R5");
    // Successful SC clears all matching reservations (R7)
    cmd(0, 2'b01, 4'd1, 8'h00); cmd(1, 2'b01, 4'd1, 8'h00); tick("R7");
    cmd(0, 2'b10, 4'd1, 8'hA1); tick("R7");
    cmd(1, 2'b10, 4'd1, 8'hA2); tick("R7");
    cmd(0, 2'b10, 4'd1, 8'hA3); tick("R7");
    // New LL replaces reservation (R8)
    cmd(2, 2'b01, 4'd0, 8'h00); tick("R8");
    cmd(2, 2'b01, 4'd3, 8'h00); tick("R8");
    cmd(2, 2'b10, 4'd0, 8'hB0); tick("R8");
    cmd(2, 2'b10, 4'd3, 8'hB3); tick("R8");
    // Same-cycle ordering (R9)
    cmd(1, 2'b01, 4'd2, 8'h00); cmd(2, 2'b01, 4'd2, 8'h00); tick("R9");
    cmd(1, 2'b10, 4'd2, 8'hC1); cmd(2, 2'b10, 4'd2, 8'hC2); tick("R9");
    cmd(0, 2'b01, 4'd2, 8'h00); tick("R9");
    cmd(0, 2'b01, 4'd0, 8'h00); tick("R9");
    cmd(0, 2'b10, 4'd0, 8'hC5); b_sv = 1'b1; b_sa = 4'd0; tick("R9");
    cmd(2, 2'b01, 4'd1, 8'h00); tick("R9");
    cmd(0, 2'b11, 4'd1, 8'hC0); cmd(2, 2'b10, 4'd1, 8'hC7); tick("R9");
    cmd(1, 2'b01, 4'd1, 8'h00); tick("R9");
    // LL racing a write (R10)
    cmd(0, 2'b01, 4'd3, 8'h00); cmd(1, 2'b11, 4'd3, 8'hD3); tick("R10");
    cmd(0, 2'b10, 4'd3, 8'hD4); tick("R10");
    cmd(2, 2'b01, 4'd0, 8'h00); b_sv = 1'b1; b_sa = 4'd0; tick("R10");
    cmd(2, 2'b10, 4'd0, 8'hD5); tick("R10");
    cmd(2, 2'b01, 4'd0, 8'h00); tick("R10");
    // Reset drops reservations (R11)
    cmd(0, 2'b01, 4'd3, 8'h00); tick("R11");
    tick("R11");
    do_reset();
    cmd(0, 2'b10, 4'd3, 8'hE3); tick("R11");
    cmd(1, 2'b01, 4'd3, 8'h00); tick("R11");
    repeat (3) @(posedge clk);
    check(q.size() == 0, "R2", "pending responses", q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule